// File: doc/BRIEF.md
# Knock-Processor Configuration Port with Glitch-Filtered Serial Load

This block is the programming front end of an engine knock signal processor. A host writes 8-bit command words over a four-wire serial bus. Each word carries a short address prefix followed by a value, and the block steers that value into one of five configuration registers: bandpass centre-frequency code, gain code, integrator time-constant code, test/channel word, and prescaler word with a serial-out disable flag. The analog chain that uses these codes lies outside this block.

The serial pins are resynchronised into a fast system clock, and all edge detection takes place in that domain. A framing filter protects the registers from noisy or partial transfers. A word lands in its register only when chip select rises at the end of a clean frame of exactly eight clock pulses. Any other frame is dropped. The serial output has an enable. It is normally driven only while the block is selected and its disable flag is clear. When the test pin is pulled low, a diagnostic multiplexer drives the output regardless of those conditions. It then carries a stored register word, the resynchronised serial input, or a comparator bit.

Top module: `knock_cfg_spi`

## Requirements
- R1: After reset, all five registers and the disable flag are zero, and with the test pin high and chip select high, `so_d` and `so_oe` are both 0.
- R2: Bits are taken most significant first on SCK falling edges. A register changes only after chip select rises, never while bits are being shifted.
- R3: A frame is kept only if SCK is low when CS falls, exactly eight SCK pulses occur, and SCK is low when CS rises. Seven pulses, nine pulses, SCK high at CS rise, or SCK high at CS fall all leave every register unchanged.
- R4: Prefix `00` (bits 7:6) loads bits 5:0 into the frequency code. Prefix `10` loads bits 5:0 into the gain code.
- R5: Prefix `110` (bits 7:5) loads bits 4:0 into the time-constant code. Prefix `111` loads bits 4:0 into the test/channel word, whose bit 0 is the channel select (0 = channel 0, 1 = channel 1).
- R6: Prefix `01` loads bits 4:1 into the prescaler code and bit 0 into the disable flag. Bit 5 of this word is ignored and reads back as 0.
- R7: With the test pin high, `so_oe` is 0 whenever CS is high.
- R8: With the test pin high and CS low, `so_oe` is 0 when the disable flag is 1 and 1 when it is 0.
- R9: With the test pin low, `so_oe` is 1 regardless of CS and the disable flag.
- R10: In diagnostic mode, test/channel bits 3:1 pick the source of `so_d`. Codes 0 to 4 give the frequency, gain, time-constant, test/channel and prescaler register, each shown as its full 8-bit command word with its prefix. Code 5 gives the resynchronised SI. Codes 6 and 7 give `cmp_bit`.
- R11: Outside diagnostic mode, `so_d` is 0.
- R12: In register readback, the word is loaded at CS fall. Its MSB is shown until the first SCK rising edge, and each later rising edge advances one bit, so the host reads MSB first on falling edges.
- R13: Consecutive frames separated by CS high each take effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles low |
| csn | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| test_n | input | 1 | Low selects diagnostic mode |
| cmp_bit | input | 1 | Comparator bit for diagnostic output |
| freq_code | output | 6 | Bandpass centre-frequency code |
| gain_code | output | 6 | Gain code |
| tc_code | output | 5 | Integrator time-constant code |
| tst_code | output | 5 | Test/channel word (bit 0 = channel) |
| presc_code | output | 4 | Prescaler code |
| so_hiz | output | 1 | Serial-out disable flag |
| so_d | output | 1 | Serial-out data |
| so_oe | output | 1 | Serial-out drive enable |

## Verification
The embedded properties check on every cycle that the output enable follows chip select, the disable flag and the test pin. They also check that registers move only in the cycle after a detected chip-select rise, and that a frame with a pulse count other than eight leaves them untouched. The scenarios are needed to show what properties cannot see cheaply: prefix decoding into the correct field, the ignored prescaler bit, the rejection of frames that are malformed only at their edges, and the bit order of the diagnostic readback word.

// File: rtl/knock_cfg_spi.sv
module knock_cfg_spi #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       csn,
  input  logic       si,
  input  logic       test_n,
  input  logic       cmp_bit,
  output logic [5:0] freq_code,
  output logic [5:0] gain_code,
  output logic [4:0] tc_code,
  output logic [4:0] tst_code,
  output logic [3:0] presc_code,
  output logic       so_hiz,
  output logic       so_d,
  output logic       so_oe
);
  logic [SYNC-1:0] sck_p, cs_p, si_p;
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; cs_p <= '1; si_p <= '0; sck_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      sck_p <= {sck_p[SYNC-2:0], sck};
      cs_p  <= {cs_p[SYNC-2:0], csn};
      si_p  <= {si_p[SYNC-2:0], si};
      sck_q <= sck_p[SYNC-1];
      cs_q  <= cs_p[SYNC-1];
    end

  wire sck_s = sck_p[SYNC-1];
  wire cs_s  = cs_p[SYNC-1];
  wire si_s  = si_p[SYNC-1];
  wire sck_rise = sck_s & ~sck_q;
  wire sck_fall = ~sck_s & sck_q;
  wire cs_fall  = ~cs_s & cs_q;
  wire cs_rise  = cs_s & ~cs_q;

  logic       ok, rb_hold;
  logic [3:0] cnt;
  logic [7:0] sr, rb, rd_word;
  wire  [2:0] src = tst_code[3:1];
  wire        diag = ~test_n;

  always_comb
    case (src)
      3'd0:    rd_word = {2'b00, freq_code};
      3'd1:    rd_word = {2'b10, gain_code};
      3'd2:    rd_word = {3'b110, tc_code};
      3'd3:    rd_word = {3'b111, tst_code};
      3'd4:    rd_word = {3'b010, presc_code, so_hiz};
      default: rd_word = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ok <= 1'b0; cnt <= '0; sr <= '0; rb <= '0; rb_hold <= 1'b0;
    end else if (cs_fall) begin
      ok <= ~sck_s; cnt <= '0; rb <= rd_word; rb_hold <= 1'b1;
    end else if (!cs_s) begin
      if (sck_fall) begin
        sr <= {sr[6:0], si_s};
        if (cnt != 4'hF) cnt <= cnt + 4'd1;
      end
      if (sck_rise) begin
        if (rb_hold) rb_hold <= 1'b0;
        else         rb <= {rb[6:0], 1'b0};
      end
    end

  wire commit = cs_rise & ok & (cnt == 4'd8) & ~sck_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      freq_code <= '0; gain_code <= '0; tc_code <= '0;
      tst_code <= '0; presc_code <= '0; so_hiz <= 1'b0;
    end else if (commit) begin
      casez (sr[7:5])
        3'b00?: freq_code <= sr[5:0];
        3'b10?: gain_code <= sr[5:0];
        3'b110: tc_code   <= sr[4:0];
        3'b111: tst_code  <= sr[4:0];
        default: begin presc_code <= sr[4:1]; so_hiz <= sr[0]; end
      endcase
    end

  assign so_oe = diag | (~cs_s & ~so_hiz);
  assign so_d  = !diag ? 1'b0 :
                 (src <= 3'd4) ? rb[7] :
                 (src == 3'd5) ? si_s : cmp_bit;

  wire [26:0] regs_all = {freq_code, gain_code, tc_code, tst_code, presc_code, so_hiz};

  // R2
  commit_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_all) |-> $past(cs_rise));
  // R3
  bad_count_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != 4'd8) |=> $stable(regs_all));
  // R7
  cs_high_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && test_n) |-> !so_oe);
  // R8
  flag_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_hiz && test_n) |-> !so_oe);
  // R9
  diag_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_n |-> so_oe);
endmodule

// File: tb/sim_knock_cfg_spi.sv
module sim_knock_cfg_spi;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 8;
  localparam logic [28:0] REGM = {{27{1'b1}}, 2'b00};
  localparam logic [28:0] SOM  = 29'b11;
  localparam logic [28:0] OEM  = 29'b01;

  logic clk = 0, rst_n = 0, sck = 0, csn = 1, si = 0, test_n = 1, cmp_bit = 0;
  logic [5:0] freq_code, gain_code;
  logic [4:0] tc_code, tst_code;
  logic [3:0] presc_code;
  logic so_hiz, so_d, so_oe;

  knock_cfg_spi u0 (.clk, .rst_n, .sck, .csn, .si, .test_n, .cmp_bit,
    .freq_code, .gain_code, .tc_code, .tst_code, .presc_code, .so_hiz, .so_d, .so_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, pend = 0;
  typedef struct { logic [28:0] mask; logic [28:0] val; string req; } exp_t;
  exp_t sb_q[$];
  wire [28:0] obs = {freq_code, gain_code, tc_code, tst_code, presc_code, so_hiz, so_d, so_oe};

  logic [5:0] m_freq = 0, m_gain = 0;
  logic [4:0] m_tc = 0, m_tst = 0;
  logic [3:0] m_presc = 0;
  logic       m_z = 0;

  function automatic logic [28:0] model_obs(input logic d, input logic oe);
    return {m_freq, m_gain, m_tc, m_tst, m_presc, m_z, d, oe};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_obs(input logic [28:0] mask, input logic [28:0] val, input string req);
    exp_t e;
    e.mask = mask; e.val = val; e.req = req;
    sb_q.push_back(e);
    pend = 1;
    wait (pend == 0);
  endtask

  initial forever begin
    exp_t e;
    wait (pend == 1);
    @(negedge clk);
    e = sb_q.pop_front();
    checks++;
    if ((obs & e.mask) !== (e.val & e.mask)) begin
      fails++;
      $display("FAIL %s: got %h expected %h", e.req, obs & e.mask, e.val & e.mask);
    end
    pend = 0;
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] w, input int np, input bit hi_start, input bit hi_end,
                      input bit peek, output logic [7:0] got);
    got = '0;
    if (hi_start) sck = 1;
    wait_clk(HALF);
    csn = 0; wait_clk(HALF);
    if (hi_start) begin sck = 0; wait_clk(HALF); end
    for (int i = 0; i < np; i++) begin
      si = (i < 8) ? w[7-i] : 1'b0;
      wait_clk(HALF/2);
      sck = 1; wait_clk(HALF);
      if (i < 8) got[7-i] = so_d;
      sck = 0; wait_clk(HALF/2);
    end
    if (hi_end) begin sck = 1; wait_clk(HALF); end
    if (peek) expect_obs(REGM, model_obs(0, 0), "R2 no change before CS rise");
    csn = 1; wait_clk(HALF);
    sck = 0; wait_clk(HALF);
  endtask

  task automatic write_word(input logic [7:0] w);
    logic [7:0] g;
    xfer(w, 8, 0, 0, 0, g);
    casez (w[7:5])
      3'b00?: m_freq = w[5:0];
      3'b10?: m_gain = w[5:0];
      3'b110: m_tc = w[4:0];
      3'b111: m_tst = w[4:0];
      default: begin m_presc = w[4:1]; m_z = w[0]; end
    endcase
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] g, wk, ew;
    wait_clk(4); rst_n = 1; wait_clk(4);
    // R1
    expect_obs({29{1'b1}}, 29'd0, "R1 reset state");

    // R4, R2
    write_word(8'h0A);
    expect_obs(REGM, model_obs(0, 0), "R4 freq load");
    xfer(8'h3F, 8, 0, 0, 1, g); m_freq = 6'h3F;
    expect_obs(REGM, model_obs(0, 0), "R2 commit on CS rise");
    write_word(8'h94);
    expect_obs(REGM, model_obs(0, 0), "R4 gain load");
    // R5
    write_word(8'hC3);
    expect_obs(REGM, model_obs(0, 0), "R5 time constant load");
    write_word(8'hE1);
    expect_obs(REGM, model_obs(0, 0), "R5 channel 1 select");
    // R6
    write_word(8'h7B);
    expect_obs(REGM, model_obs(0, 0), "R6 prescaler bit5 ignored");

    // R3 malformed frames
    xfer(8'h00, 7, 0, 0, 0, g);
    expect_obs(REGM, model_obs(0, 0), "R3 seven pulses dropped");
    xfer(8'h00, 9, 0, 0, 0, g);
    expect_obs(REGM, model_obs(0, 0), "R3 nine pulses dropped");
    xfer(8'h00, 8, 0, 1, 0, g);
    expect_obs(REGM, model_obs(0, 0), "R3 SCK high at CS rise dropped");
    xfer(8'h00, 8, 1, 0, 0, g);
    expect_obs(REGM, model_obs(0, 0), "R3 SCK high at CS fall dropped");

    // R7, R8, R11
    expect_obs(SOM, 29'b00, "R7 CS high disables output");
    csn = 0; wait_clk(4);
    expect_obs(SOM, 29'b00, "R8 flag forces high impedance");
    csn = 1; wait_clk(HALF);
    write_word(8'h5A);
    csn = 0; wait_clk(4);
    expect_obs(SOM, 29'b01, "R8 R11 active output with data 0");
    csn = 1; wait_clk(4);
    expect_obs(SOM, 29'b00, "R7 CS high again");

    // R9
    write_word(8'h5B);
    test_n = 0; wait_clk(2);
    expect_obs(OEM, 29'b1, "R9 diagnostic overrides CS and flag");

    // R10, R12 register readback
    for (int k = 0; k < 5; k++) begin
      wk = {3'b111, 1'b0, k[2:0], k[0]};
      write_word(wk);
      case (k)
        0: ew = {2'b00, m_freq};
        1: ew = {2'b10, m_gain};
        2: ew = {3'b110, m_tc};
        3: ew = wk;
        default: ew = {3'b010, m_presc, m_z};
      endcase
      xfer(wk, 8, 0, 0, 0, g);
      chk($sformatf("R10 R12 readback source %0d", k), g, ew);
    end

    // R10 SI and comparator sources
    write_word(8'hEA);
    si = 1; wait_clk(4);
    expect_obs(SOM, 29'b11, "R10 SI source high");
    si = 0; wait_clk(4);
    expect_obs(SOM, 29'b01, "R10 SI source low");
    write_word(8'hEC);
    cmp_bit = 1; wait_clk(2);
    expect_obs(SOM, 29'b11, "R10 comparator source high");
    cmp_bit = 0; wait_clk(2);
    expect_obs(SOM, 29'b01, "R10 comparator source low");
    write_word(8'hEE);
    cmp_bit = 1; wait_clk(2);
    expect_obs(SOM, 29'b11, "R10 comparator code 7");
    cmp_bit = 0;

    // R11
    test_n = 1; si = 1; wait_clk(4);
    expect_obs(SOM, 29'b00, "R11 data zero outside diagnostic");
    si = 0;

    // R13 consecutive frames
    write_word(8'h15);
    write_word(8'h80);
    write_word(8'hDF);
    expect_obs(REGM, model_obs(0, 0), "R13 back-to-back words");

    summary();
    $finish;
  end
endmodule